// File: doc/BRIEF.md
# Linked Descriptor Queue Engine

This block sequences one direction of a DMA channel. The host lays out a chain of four-word descriptors in a local descriptor RAM. Each descriptor holds, at consecutive word addresses starting at its pointer, the next pointer (offset 0), the buffer address (offset 1), the buffer length (offset 2) and the mode/flags word (offset 3). The host writes the pointer of the first descriptor to the head register. The engine fetches the descriptor and hands the buffer to an external data mover. When the mover reports the bytes it moved, the engine writes the mode word back with ownership returned to the host. It then publishes the descriptor pointer as the completion pointer and raises a completion event.

The host acknowledges each completion by writing the same pointer back. The engine then follows the chain, or goes idle and marks end-of-queue when the next pointer is null. A teardown command, addressed by channel number, stops the chain at the next descriptor boundary. The engine marks that descriptor as torn down and signals the end of the teardown with the completion value 0xFFFFFFFC, which the host acknowledges with the same value. When built as a receive channel (`IS_TX` = 0), the engine ignores the directed-port field.

Top module: `ldq_engine`

## Requirements
- R1: After reset, done_o, busy_o, mv_req_o and cp_o are all 0.
- R2: A head write of a nonzero word-aligned pointer while idle starts a fetch of the four descriptor words. A head write of zero is ignored.
- R3: For a descriptor whose owner bit (mode bit 29) is set, the engine raises mv_req_o. The request carries the buffer word as mv_addr_o and bits 10:0 of the length word as mv_len_o. It holds the request until mv_done_i.
- R4: The write-back of the mode word clears bit 29 and puts mv_bytes_i into bits 10:0. It keeps every other bit and sets end-of-queue (bit 28) exactly when the next pointer is zero.
- R5: After the write-back, cp_o equals the descriptor pointer and done_o is high. done_o stays high until a completion-pointer write equal to cp_o. A write of any other value is ignored, and no further descriptor is started before the acknowledge.
- R6: After the acknowledge, a nonzero next pointer is followed. A zero next pointer leaves the engine idle. A later head write restarts it, including for a descriptor linked after the end of the queue.
- R7: A fetched descriptor whose owner bit is clear produces no transfer, no write-back and no completion, and the engine returns to idle.
- R8: On a transmit channel, mode bit 20 set drives mv_port_vld_o with mv_port_o = mode bits 18:16. With bit 20 clear, mv_port_vld_o is 0.
- R9: A teardown write carrying a value other than CHAN_ID has no effect.
- R10: A teardown while idle sets cp_o to 0xFFFFFFFC and raises done_o.
- R11: During a chain, a teardown lets the current transfer complete normally. The next owned descriptor gets teardown-complete (bit 27), end-of-queue (bit 28) and owner clear, with no transfer, and then cp_o becomes 0xFFFFFFFC with done_o high.
- R12: Head writes are ignored until the host writes 0xFFFFFFFC to the completion pointer. That write ends the teardown and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hp_wr_i | input | 1 | Head-pointer write strobe |
| cp_wr_i | input | 1 | Completion-pointer write strobe (acknowledge) |
| td_wr_i | input | 1 | Teardown command write strobe |
| host_wdata_i | input | 32 | Host write data for all three registers |
| cp_o | output | 32 | Completion pointer |
| done_o | output | 1 | Completion event outstanding |
| busy_o | output | 1 | Engine not idle |
| ram_req_o | output | 1 | Descriptor RAM access |
| ram_we_o | output | 1 | Descriptor RAM write enable |
| ram_addr_o | output | AW | Descriptor RAM word address |
| ram_wdata_o | output | 32 | Descriptor RAM write data |
| ram_rdata_i | input | 32 | Descriptor RAM read data, one cycle after the request |
| mv_req_o | output | 1 | Transfer request to the data mover |
| mv_addr_o | output | 32 | Buffer address |
| mv_len_o | output | 11 | Buffer length |
| mv_port_o | output | 3 | Directed port number |
| mv_port_vld_o | output | 1 | Directed port valid |
| mv_done_i | input | 1 | Transfer finished pulse |
| mv_bytes_i | input | 11 | Bytes moved, valid with mv_done_i |

## Verification
On every cycle, the assertions check that a completion stays raised with a stable pointer until the host writes, and that no transfer runs while a completion is pending. They also check that a mover request holds steady until done, that every descriptor write-back returns ownership, and that each new completion carries either an aligned pointer or the teardown value. Only the bench scenarios can show the rest. Those include the exact write-back contents and end-of-queue placement, following a chain versus stopping, the skip of a non-owned descriptor and the restart after end-of-queue. They also include the teardown marking of the following descriptor and the head writes ignored until the teardown is acknowledged.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  localparam int DW       = 32;
  localparam int LEN_W    = 11;
  localparam int PORT_W   = 3;
  localparam int B_SOP    = 31;
  localparam int B_EOP    = 30;
  localparam int B_OWN    = 29;
  localparam int B_EOQ    = 28;
  localparam int B_TDC    = 27;
  localparam int B_CRC    = 26;
  localparam int B_DIR    = 20;
  localparam int B_PORT   = 16;
  localparam logic [DW-1:0] TD_MAGIC = 32'hFFFF_FFFC;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_CHK, S_MOVE, S_WB, S_ACK, S_TDCP, S_TDWAIT
  } ldq_state_e;

  function automatic logic [DW-1:0] wb_mode(logic [DW-1:0] m, logic [LEN_W-1:0] n, logic last);
    logic [DW-1:0] r;
    r = m;
    r[B_OWN] = 1'b0;
    r[LEN_W-1:0] = n;
    if (last) r[B_EOQ] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] td_mode(logic [DW-1:0] m);
    logic [DW-1:0] r;
    r = m;
    r[B_OWN] = 1'b0;
    r[B_TDC] = 1'b1;
    r[B_EOQ] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ldq_td_ctrl.sv
module ldq_td_ctrl import ldq_pkg::*; #(
  parameter logic [DW-1:0] CHAN_ID = 32'd3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          td_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic          pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pend_o <= 1'b0;
    else if (clr_i)                       pend_o <= 1'b0;
    else if (td_wr_i && wdata_i == CHAN_ID) pend_o <= 1'b1;
  end
endmodule

// File: rtl/ldq_cpl_reg.sv
module ldq_cpl_reg import ldq_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [DW-1:0] val_i,
  input  logic          cp_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cp_o,
  output logic          done_o,
  output logic          ack_o
);
  assign ack_o = done_o && cp_wr_i && (wdata_i == cp_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cp_o   <= '0;
      done_o <= 1'b0;
    end else if (set_i) begin
      cp_o   <= val_i;
      done_o <= 1'b1;
    end else if (ack_o) begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ldq_port_sel.sv
module ldq_port_sel import ldq_pkg::*; #(
  parameter bit IS_TX = 1'b1
) (
  input  logic              active_i,
  input  logic [DW-1:0]     mode_i,
  output logic [PORT_W-1:0] port_o,
  output logic              vld_o
);
  if (IS_TX) begin : g_tx
    assign vld_o  = active_i && mode_i[B_DIR];
    assign port_o = vld_o ? mode_i[B_PORT +: PORT_W] : '0;
  end else begin : g_rx
    assign vld_o  = 1'b0;
    assign port_o = '0;
  end
endmodule

// File: rtl/ldq_engine.sv
module ldq_engine import ldq_pkg::*; #(
  parameter int            AW      = 8,
  parameter logic [DW-1:0] CHAN_ID = 32'd3,
  parameter bit            IS_TX   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hp_wr_i,
  input  logic              cp_wr_i,
  input  logic              td_wr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     cp_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              mv_req_o,
  output logic [DW-1:0]     mv_addr_o,
  output logic [LEN_W-1:0]  mv_len_o,
  output logic [PORT_W-1:0] mv_port_o,
  output logic              mv_port_vld_o,
  input  logic              mv_done_i,
  input  logic [LEN_W-1:0]  mv_bytes_i
);
  localparam logic [AW-1:0] OFS_BUF  = AW'(1);
  localparam logic [AW-1:0] OFS_LEN  = AW'(2);
  localparam logic [AW-1:0] OFS_MODE = AW'(3);

  ldq_state_e       state_q;
  logic [DW-1:0]    ptr_q, next_q, buf_q, mode_q;
  logic [LEN_W-1:0] len_q, bytes_q;
  logic [DW-1:0]    head_w;
  logic             td_pend, td_clr, cpl_set, ack_ok;
  logic [DW-1:0]    cpl_val;

  assign head_w = {host_wdata_i[DW-1:2], 2'b00};

  ldq_td_ctrl #(.CHAN_ID(CHAN_ID)) i_td (
    .clk_i, .rst_ni, .td_wr_i, .wdata_i(host_wdata_i), .clr_i(td_clr), .pend_o(td_pend)
  );

  ldq_cpl_reg i_cpl (
    .clk_i, .rst_ni, .set_i(cpl_set), .val_i(cpl_val), .cp_wr_i,
    .wdata_i(host_wdata_i), .cp_o, .done_o, .ack_o(ack_ok)
  );

  ldq_port_sel #(.IS_TX(IS_TX)) i_port (
    .active_i(mv_req_o), .mode_i(mode_q), .port_o(mv_port_o), .vld_o(mv_port_vld_o)
  );

  assign cpl_set   = (state_q == S_WB) || (state_q == S_TDCP);
  assign cpl_val   = (state_q == S_TDCP) ? TD_MAGIC : ptr_q;
  assign td_clr    = (state_q == S_TDWAIT) && ack_ok;
  assign busy_o    = (state_q != S_IDLE);
  assign mv_req_o  = (state_q == S_MOVE);
  assign mv_addr_o = buf_q;
  assign mv_len_o  = len_q;

  always_comb begin
    ram_req_o   = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = ptr_q[AW-1:0];
    ram_wdata_o = '0;
    unique case (state_q)
      S_F0: ram_req_o = 1'b1;
      S_F1: begin ram_req_o = 1'b1; ram_addr_o = ptr_q[AW-1:0] + OFS_BUF;  end
      S_F2: begin ram_req_o = 1'b1; ram_addr_o = ptr_q[AW-1:0] + OFS_LEN;  end
      S_F3: begin ram_req_o = 1'b1; ram_addr_o = ptr_q[AW-1:0] + OFS_MODE; end
      S_CHK: if (td_pend && ram_rdata_i[B_OWN]) begin
        ram_req_o   = 1'b1;
        ram_we_o    = 1'b1;
        ram_addr_o  = ptr_q[AW-1:0] + OFS_MODE;
        ram_wdata_o = td_mode(ram_rdata_i);
      end
      S_WB: begin
        ram_req_o   = 1'b1;
        ram_we_o    = 1'b1;
        ram_addr_o  = ptr_q[AW-1:0] + OFS_MODE;
        ram_wdata_o = wb_mode(mode_q, bytes_q, next_q == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      mode_q  <= '0;
      len_q   <= '0;
      bytes_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (td_pend) state_q <= S_TDCP;
          else if (hp_wr_i && head_w != '0) begin
            ptr_q   <= head_w;
            state_q <= S_F0;
          end
        end
        S_F0: state_q <= S_F1;
        S_F1: begin next_q <= {ram_rdata_i[DW-1:2], 2'b00}; state_q <= S_F2; end
        S_F2: begin buf_q  <= ram_rdata_i; state_q <= S_F3; end
        S_F3: begin len_q  <= ram_rdata_i[LEN_W-1:0]; state_q <= S_CHK; end
        S_CHK: begin
          mode_q <= ram_rdata_i;
          if (td_pend)                  state_q <= S_TDCP;
          else if (ram_rdata_i[B_OWN])  state_q <= S_MOVE;
          else                          state_q <= S_IDLE;
        end
        S_MOVE: if (mv_done_i) begin
          bytes_q <= mv_bytes_i;
          state_q <= S_WB;
        end
        S_WB: state_q <= S_ACK;
        S_ACK: if (ack_ok) begin
          if (next_q != '0) begin
            ptr_q   <= next_q;
            state_q <= S_F0;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_TDCP:   state_q <= S_TDWAIT;
        S_TDWAIT: if (ack_ok) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldq_checker.sv
module ldq_checker import ldq_pkg::*; (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic [DW-1:0] cp_o,
  input logic          cp_wr_i,
  input logic          mv_req_o,
  input logic          mv_done_i,
  input logic [DW-1:0] mv_addr_o,
  input logic          mv_port_vld_o,
  input logic          ram_we_o,
  input logic [DW-1:0] ram_wdata_o
);
  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !cp_wr_i |=> done_o);
  p_cp_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !cp_wr_i |=> $stable(cp_o));
  p_no_move_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mv_req_o);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_req_o && !mv_done_i |=> mv_req_o && $stable(mv_addr_o));
  p_wb_owner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !ram_wdata_o[B_OWN]);
  p_port_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_port_vld_o |-> mv_req_o);
  p_cp_form_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cp_o == TD_MAGIC) || (cp_o != '0 && cp_o[1:0] == 2'b00));
endmodule

bind ldq_engine ldq_checker i_ldq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .cp_o(cp_o), .cp_wr_i(cp_wr_i),
  .mv_req_o(mv_req_o), .mv_done_i(mv_done_i), .mv_addr_o(mv_addr_o),
  .mv_port_vld_o(mv_port_vld_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o)
);

// File: tb/test_ldq_engine.sv
module test_ldq_engine;
  localparam int AW = 8;
  localparam logic [31:0] CID   = 32'd3;
  localparam logic [31:0] MAGIC = 32'hFFFF_FFFC;
  localparam logic [31:0] OWN = 32'h2000_0000, EOQ = 32'h1000_0000, TDC = 32'h0800_0000;
  localparam logic [31:0] SOPEOP = 32'hC000_0000, DIR = 32'h0010_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hp_wr = 0, cp_wr = 0, td_wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] cp;
  logic done, busy, ram_req, ram_we;
  logic [AW-1:0] ram_addr;
  logic [31:0] ram_wdata, ram_rdata;
  logic mv_req, mv_port_vld, mv_done;
  logic [31:0] mv_addr;
  logic [10:0] mv_len, mv_bytes;
  logic [2:0] mv_port;

  logic [31:0] mem [256];
  int checks = 0, fails = 0, mv_cnt = 0, slow = 0;
  logic [31:0] last_addr;
  logic [10:0] last_len, last_bytes;
  logic [2:0]  last_port;
  logic        last_vld;
  bit finished = 0;

  always #4 clk = ~clk;

  ldq_engine #(.AW(AW), .CHAN_ID(CID), .IS_TX(1'b1)) i_ldq_engine (
    .clk_i(clk), .rst_ni(rst_n), .hp_wr_i(hp_wr), .cp_wr_i(cp_wr), .td_wr_i(td_wr),
    .host_wdata_i(wdata), .cp_o(cp), .done_o(done), .busy_o(busy),
    .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata), .mv_req_o(mv_req), .mv_addr_o(mv_addr), .mv_len_o(mv_len),
    .mv_port_o(mv_port), .mv_port_vld_o(mv_port_vld), .mv_done_i(mv_done), .mv_bytes_i(mv_bytes)
  );

  always @(posedge clk) begin
    if (ram_req && ram_we) mem[ram_addr] <= ram_wdata;
    else if (ram_req)      ram_rdata <= mem[ram_addr];
  end

  // data mover model
  initial begin
    mv_done = 0; mv_bytes = '0;
    forever begin
      @(negedge clk);
      if (mv_req && !mv_done) begin
        mv_cnt++;
        last_addr = mv_addr; last_len = mv_len; last_port = mv_port; last_vld = mv_port_vld;
        last_bytes = (mv_len > 11'd4) ? mv_len - 11'($urandom % 4) : mv_len;
        repeat (slow ? 8 : 1 + ($urandom % 4)) @(negedge clk);
        mv_bytes = last_bytes; mv_done = 1;
        @(negedge clk);
        mv_done = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int kind, logic [31:0] v);
    @(negedge clk);
    wdata = v;
    if (kind == 0) hp_wr = 1; else if (kind == 1) cp_wr = 1; else td_wr = 1;
    @(negedge clk);
    hp_wr = 0; cp_wr = 0; td_wr = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] exp_wb(logic [31:0] m, logic [10:0] n, bit last);
    logic [31:0] r;
    r = (m & ~OWN & ~32'h7FF) | {21'd0, n};
    if (last) r = r | EOQ;
    return r;
  endfunction

  task automatic put_desc(logic [31:0] p, logic [31:0] nxt, logic [31:0] bufa,
                          logic [10:0] len, logic [31:0] mode);
    mem[p[7:0]] = nxt; mem[p[7:0]+1] = bufa; mem[p[7:0]+2] = {21'd0, len}; mem[p[7:0]+3] = mode;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    int c0;
    logic [31:0] p [3];
    logic [31:0] md [3];
    logic [31:0] bf [3];
    logic [10:0] ln [3];
    void'($urandom(32'd7731));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !busy && !mv_req && cp == 0, "R1", {28'd0, done, busy, mv_req, 1'b0} | cp, 0);

    // R2 zero head ignored
    wr(0, 32'd0);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 zero head", {31'd0, busy}, 0);

    // random chains: R3 R4 R5 R6 R8
    for (int it = 0; it < 30; it++) begin
      int n;
      n = 1 + ($urandom % 3);
      for (int j = 0; j < n; j++) begin
        p[j]  = 32'(4 * (1 + ((it * 3 + j) % 60)));
        bf[j] = $urandom;
        ln[j] = 11'(1 + ($urandom % 2047));
        md[j] = OWN | SOPEOP | (($urandom % 2) ? DIR : 0) | (32'($urandom % 8) << 16) | {21'd0, ln[j]};
      end
      for (int j = 0; j < n; j++)
        put_desc(p[j], (j == n - 1) ? 32'd0 : p[j + 1], bf[j], ln[j], md[j]);
      c0 = mv_cnt;
      wr(0, p[0]);
      for (int j = 0; j < n; j++) begin
        wait_done(ok);
        chk(ok && cp == p[j], "R5 completion pointer", cp, p[j]);
        chk(last_addr == bf[j] && last_len == ln[j], "R3 mover request", last_addr, bf[j]);
        chk(last_vld == md[j][20] && last_port == (md[j][20] ? md[j][18:16] : 3'd0),
            "R8 directed port", {28'd0, last_vld, last_port}, {28'd0, md[j][20], md[j][18:16]});
        chk(mem[p[j][7:0] + 3] == exp_wb(md[j], last_bytes, j == n - 1), "R4 write-back",
            mem[p[j][7:0] + 3], exp_wb(md[j], last_bytes, j == n - 1));
        if (it == 0 && j == 0) begin
          wr(1, p[j] + 4);
          repeat (3) @(negedge clk);
          chk(done && mv_cnt == c0 + 1, "R5 wrong ack ignored", {31'd0, done}, 1);
        end
        wr(1, p[j]);
      end
      repeat (3) @(negedge clk);
      chk(!busy && !done && mv_cnt == c0 + n, "R6 chain end idle", mv_cnt - c0, n);
    end

    // R6 restart after end of queue with a late-linked descriptor
    put_desc(32'd200, 0, 32'h1111_0000, 11'd64, OWN | SOPEOP | 32'd64);
    wr(0, 32'd200);
    wait_done(ok);
    wr(1, 32'd200);
    put_desc(32'd204, 0, 32'h2222_0000, 11'd32, OWN | SOPEOP | 32'd32);
    mem[200] = 32'd204;
    repeat (3) @(negedge clk);
    chk(!busy, "R6 idle after eoq", {31'd0, busy}, 0);
    wr(0, 32'd204);
    wait_done(ok);
    chk(ok && cp == 32'd204 && last_addr == 32'h2222_0000, "R6 restart", cp, 32'd204);
    wr(1, 32'd204);

    // R7 owner clear descriptor
    put_desc(32'd208, 0, 32'h3333_0000, 11'd16, SOPEOP | 32'd16);
    c0 = mv_cnt;
    wr(0, 32'd208);
    repeat (15) @(negedge clk);
    chk(!busy && !done && mv_cnt == c0 && mem[211] == (SOPEOP | 32'd16), "R7 not owned",
        mem[211], SOPEOP | 32'd16);

    // R9 wrong channel teardown
    wr(2, CID + 1);
    repeat (5) @(negedge clk);
    chk(!done && !busy, "R9 wrong channel", {30'd0, done, busy}, 0);

    // R10 teardown in idle, R12 head ignored until ack
    wr(2, CID);
    wait_done(ok);
    chk(ok && cp == MAGIC, "R10 idle teardown", cp, MAGIC);
    put_desc(32'd212, 0, 32'h4444_0000, 11'd40, OWN | SOPEOP | 32'd40);
    c0 = mv_cnt;
    wr(0, 32'd212);
    wr(1, 32'd0);
    repeat (5) @(negedge clk);
    chk(done && mv_cnt == c0, "R12 head ignored during teardown", {31'd0, done}, 1);
    wr(1, MAGIC);
    repeat (3) @(negedge clk);
    chk(!done && !busy && mem[215][29], "R12 teardown ack", mem[215], OWN | SOPEOP | 32'd40);
    wr(0, 32'd212);
    wait_done(ok);
    chk(ok && cp == 32'd212, "R12 usable after teardown", cp, 32'd212);
    wr(1, 32'd212);

    // R11 teardown during a chain
    put_desc(32'd220, 32'd224, 32'h5555_0000, 11'd100, OWN | SOPEOP | 32'd100);
    put_desc(32'd224, 0, 32'h6666_0000, 11'd80, OWN | SOPEOP | 32'd80);
    slow = 1;
    c0 = mv_cnt;
    wr(0, 32'd220);
    for (int k = 0; k < 50 && !mv_req; k++) @(negedge clk);
    wr(2, CID);
    wait_done(ok);
    chk(ok && cp == 32'd220, "R11 current completes", cp, 32'd220);
    chk(mem[223] == exp_wb(OWN | SOPEOP | 32'd100, last_bytes, 0), "R11 current write-back",
        mem[223], exp_wb(OWN | SOPEOP | 32'd100, last_bytes, 0));
    wr(1, 32'd220);
    wait_done(ok);
    chk(ok && cp == MAGIC, "R11 teardown value", cp, MAGIC);
    chk(mem[227] == ((SOPEOP | 32'd80 | TDC | EOQ)) && mv_cnt == c0 + 1, "R11 marked",
        mem[227], SOPEOP | 32'd80 | TDC | EOQ);
    wr(1, MAGIC);
    slow = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R12 idle after ack", {30'd0, busy, done}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule